// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block converts a logical address, made of a segment register choice and a 32-bit offset, into a 32-bit linear address. It keeps six segment registers. Each one caches a copy of its segment's base, limit, privilege and type. That copy is filled when software loads a selector, and every later translation uses only the cached copy, with no memory access.

A selector load is a 16-bit value. Bits [15:3] are the descriptor index, bit 2 picks the local table (1) or the global table (0), and bits [1:0] are the requested privilege level. The unit checks the index against the chosen table's limit. It then fetches the 8-byte descriptor with two 32-bit reads at `tableBase + index*8` and `+4`. It checks the present bit and the privilege level, and only then writes the cached copy. Word 0 of a descriptor is the 32-bit base. Word 1 holds the limit in bits [19:0] (in bytes, inclusive), the descriptor privilege in [21:20], present in [22], a read/write permission bit in [23] and code (1) or data (0) in [24]. Bits [31:25] are reserved and must be zero.

A translation returns, one cycle after it is requested, either `base + offset` (modulo 2^32) or a fault code. Segment registers are numbered 0 code, 1 stack, 2 data, 3..5 extra data. Access kinds are 0 read, 1 write and 2 execute.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset no load is in progress (`busy`=0), and every segment register is unloaded: a translation through it faults with code 3.
- R2: A load reads exactly two words, first at tableBase+index*8 and then at +4, from the local table when selector bit 2 is 1 and from the global table otherwise. The read request and its address stay steady until `memRdReady`.
- R3: A translation request produces `xlDone` in the next cycle. Without a fault, `xlLinear` = cached base + offset, wrapping at 2^32.
- R4: An offset greater than the cached limit faults with code 1, and a faulting translation reports `xlLinear`=0. Offset equal to the limit is allowed.
- R5: The type check faults with code 2. Execute needs a code segment. Write needs a data segment with bit 23 set. Read needs a data segment, or a code segment with bit 23 set. The limit check takes priority over the type check.
- R6: If index*8+7 exceeds the selected table limit, the load ends with code 4, issues no memory read and leaves the register unchanged.
- R7: A descriptor with present clear, or with any reserved bit set, ends the load with code 5 and leaves the register unchanged.
- R8: If max(current privilege, requested privilege) > descriptor privilege, the load ends with code 6 and leaves the register unchanged. Code 5 takes priority over code 6.
- R9: Changing a descriptor in memory does not change translations until the selector is loaded again.
- R10: `busy` is high from the cycle after a load is accepted until `ldDone`. Load requests seen while busy are ignored. `ldDone` reports code 0 on success.
- R11: The six segment registers are independent: loading one leaves the others' translations unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write a table base/limit pair |
| cfgLocal | input | 1 | 1 selects the local table, 0 the global table |
| cfgBase | input | 32 | Table base address |
| cfgLimit | input | 16 | Table byte limit (inclusive) |
| ldValid | input | 1 | Selector load request, taken when not busy |
| ldSeg | input | 3 | Segment register to load |
| ldSelector | input | 16 | Selector value |
| ldCpl | input | 2 | Current privilege level |
| busy | output | 1 | Load in progress |
| ldDone | output | 1 | Load finished (one cycle) |
| ldFault | output | 1 | Load finished with a fault |
| ldCode | output | 3 | Load fault code |
| memRdValid | output | 1 | Descriptor read request |
| memRdAddr | output | 32 | Descriptor read address |
| memRdReady | input | 1 | Read accepted; data valid this cycle |
| memRdData | input | 32 | Read data |
| xlValid | input | 1 | Translation request |
| xlSeg | input | 3 | Segment register used |
| xlOffset | input | 32 | Offset |
| xlAccess | input | 2 | 0 read, 1 write, 2 execute |
| xlDone | output | 1 | Translation result valid |
| xlFault | output | 1 | Translation faulted |
| xlCode | output | 3 | Translation fault code |
| xlLinear | output | 32 | Linear address |

## Verification
A translation result is registered, so it is due in the cycle after the edge that samples the request. The bench drives each request at a falling edge and compares the result at the next falling edge. A load reports one cycle after its last descriptor word is taken, and a table-limit abort reports two cycles after acceptance. The bench therefore waits for `busy` to fall and compares `ldDone` at that same falling edge. The memory model takes a read every other cycle and checks each read address against the sequence queued for that load, so a read that should never happen is also caught.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ADDR_W    = 32;
  localparam int SEL_W     = 16;
  localparam int IDX_W     = 13;
  localparam int LIM_W     = 20;
  localparam int TBL_LIM_W = 16;
  localparam int SEG_ID_W  = 3;

  // descriptor word 1 field positions
  localparam int D_DPL_LO  = 20;
  localparam int D_PRESENT = 22;
  localparam int D_RW      = 23;
  localparam int D_CODE    = 24;
  localparam int D_RSV_LO  = 25;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_LIMIT    = 3'd1,
    FLT_TYPE     = 3'd2,
    FLT_UNLOADED = 3'd3,
    FLT_TABLE    = 3'd4,
    FLT_ABSENT   = 3'd5,
    FLT_PRIV     = 3'd6
  } faultCode_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } access_e;

  typedef struct packed {
    logic              loaded;
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [1:0]        dpl;
    logic              isCode;
    logic              permRw;
  } segCache_t;

  typedef struct packed {
    logic latchReq;
    logic tblAbort;
    logic capLo;
    logic capHi;
    logic commit;
    logic addrHi;
  } ctrlStrobes_t;
endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ldValid,
  input  logic         tblOk,
  input  logic         memRdReady,
  output ctrlStrobes_t strobes,
  output logic         memRdValid,
  output logic         busy
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_RD_LO, S_RD_HI, S_FINISH} state_e;
  state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD     = stateQ;
    strobes    = '0;
    memRdValid = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (ldValid) begin
          strobes.latchReq = 1'b1;
          stateD = S_CHECK;
        end
      end
      S_CHECK: begin
        if (tblOk) stateD = S_RD_LO;
        else begin
          strobes.tblAbort = 1'b1;
          stateD = S_IDLE;
        end
      end
      S_RD_LO: begin
        memRdValid = 1'b1;
        if (memRdReady) begin
          strobes.capLo = 1'b1;
          stateD = S_RD_HI;
        end
      end
      S_RD_HI: begin
        memRdValid     = 1'b1;
        strobes.addrHi = 1'b1;
        if (memRdReady) begin
          strobes.capHi = 1'b1;
          stateD = S_FINISH;
        end
      end
      S_FINISH: begin
        strobes.commit = 1'b1;
        stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  assign busy = (stateQ != S_IDLE);
endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEGS = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic                 cfgWe,
  input  logic                 cfgLocal,
  input  logic [ADDR_W-1:0]    cfgBase,
  input  logic [TBL_LIM_W-1:0] cfgLimit,
  input  logic [SEG_ID_W-1:0]  ldSeg,
  input  logic [SEL_W-1:0]     ldSelector,
  input  logic [1:0]           ldCpl,
  output logic                 tblOk,
  output logic [ADDR_W-1:0]    memRdAddr,
  input  logic [31:0]          memRdData,
  output logic                 ldDone,
  output logic                 ldFault,
  output logic [2:0]           ldCode,
  input  logic                 xlValid,
  input  logic [SEG_ID_W-1:0]  xlSeg,
  input  logic [ADDR_W-1:0]    xlOffset,
  input  logic [1:0]           xlAccess,
  output logic                 xlDone,
  output logic                 xlFault,
  output logic [2:0]           xlCode,
  output logic [ADDR_W-1:0]    xlLinear
);
  localparam int ENT_SHIFT = 3;

  // descriptor table registers
  logic [ADDR_W-1:0]    gdtBaseQ, ldtBaseQ;
  logic [TBL_LIM_W-1:0] gdtLimQ, ldtLimQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gdtBaseQ <= '0; gdtLimQ <= '0;
      ldtBaseQ <= '0; ldtLimQ <= '0;
    end else if (cfgWe) begin
      if (cfgLocal) begin ldtBaseQ <= cfgBase; ldtLimQ <= cfgLimit; end
      else          begin gdtBaseQ <= cfgBase; gdtLimQ <= cfgLimit; end
    end
  end

  // latched load request and fetched descriptor words
  logic [SEL_W-1:0]    selQ;
  logic [SEG_ID_W-1:0] segQ;
  logic [1:0]          cplQ;
  logic [31:0]         wordLoQ, wordHiQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0; segQ <= '0; cplQ <= '0;
      wordLoQ <= '0; wordHiQ <= '0;
    end else begin
      if (strobes.latchReq) begin
        selQ <= ldSelector; segQ <= ldSeg; cplQ <= ldCpl;
      end
      if (strobes.capLo) wordLoQ <= memRdData;
      if (strobes.capHi) wordHiQ <= memRdData;
    end
  end

  logic [IDX_W-1:0]     reqIdx;
  logic                 reqLocal;
  logic [1:0]           reqRpl;
  logic [TBL_LIM_W-1:0] entryEnd;
  logic [ADDR_W-1:0]    tblBase;

  assign reqIdx   = selQ[SEL_W-1:ENT_SHIFT];
  assign reqLocal = selQ[2];
  assign reqRpl   = selQ[1:0];
  assign entryEnd = {reqIdx, {ENT_SHIFT{1'b1}}};
  assign tblOk    = entryEnd <= (reqLocal ? ldtLimQ : gdtLimQ);
  assign tblBase  = reqLocal ? ldtBaseQ : gdtBaseQ;
  assign memRdAddr = tblBase + ADDR_W'({reqIdx, {ENT_SHIFT{1'b0}}})
                   + (strobes.addrHi ? ADDR_W'(4) : ADDR_W'(0));

  // descriptor evaluation at commit
  logic       descPresent, privOk, commitOk;
  logic [1:0] effPl;
  faultCode_e loadCode;
  segCache_t  newCache;

  always_comb begin
    descPresent = wordHiQ[D_PRESENT] && (wordHiQ[31:D_RSV_LO] == '0);
    effPl       = (cplQ > reqRpl) ? cplQ : reqRpl;
    privOk      = effPl <= wordHiQ[D_DPL_LO +: 2];
    if (!descPresent)  loadCode = FLT_ABSENT;
    else if (!privOk)  loadCode = FLT_PRIV;
    else               loadCode = FLT_NONE;
    commitOk        = strobes.commit && (loadCode == FLT_NONE);
    newCache.loaded = 1'b1;
    newCache.base   = wordLoQ;
    newCache.limit  = wordHiQ[LIM_W-1:0];
    newCache.dpl    = wordHiQ[D_DPL_LO +: 2];
    newCache.isCode = wordHiQ[D_CODE];
    newCache.permRw = wordHiQ[D_RW];
  end

  // hidden descriptor caches, one per segment register
  segCache_t cacheQ [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : gSeg
    always_ff @(posedge clk) begin
      if (!rstN)                                      cacheQ[g] <= '0;
      else if (commitOk && segQ == SEG_ID_W'(g))      cacheQ[g] <= newCache;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldDone <= 1'b0; ldFault <= 1'b0; ldCode <= '0;
    end else begin
      ldDone <= strobes.commit | strobes.tblAbort;
      if (strobes.tblAbort) begin
        ldFault <= 1'b1; ldCode <= FLT_TABLE;
      end else if (strobes.commit) begin
        ldFault <= (loadCode != FLT_NONE); ldCode <= loadCode;
      end else begin
        ldFault <= 1'b0; ldCode <= '0;
      end
    end
  end

  // translation path
  segCache_t  hit;
  faultCode_e xCode;
  logic       typeOk;

  always_comb begin
    hit = '0;
    for (int i = 0; i < NUM_SEGS; i++)
      if (xlSeg == SEG_ID_W'(i)) hit = cacheQ[i];
    unique case (xlAccess)
      ACC_EXEC:  typeOk = hit.isCode;
      ACC_WRITE: typeOk = !hit.isCode && hit.permRw;
      ACC_READ:  typeOk = !hit.isCode || hit.permRw;
      default:   typeOk = 1'b0;
    endcase
    if (!hit.loaded)                             xCode = FLT_UNLOADED;
    else if (xlOffset > ADDR_W'(hit.limit))      xCode = FLT_LIMIT;
    else if (!typeOk)                            xCode = FLT_TYPE;
    else                                         xCode = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xlDone <= 1'b0; xlFault <= 1'b0; xlCode <= '0; xlLinear <= '0;
    end else begin
      xlDone <= xlValid;
      if (xlValid) begin
        xlFault  <= (xCode != FLT_NONE);
        xlCode   <= xCode;
        xlLinear <= (xCode == FLT_NONE) ? hit.base + xlOffset : '0;
      end else begin
        xlFault <= 1'b0; xlCode <= '0; xlLinear <= '0;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEGS = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic        cfgLocal,
  input  logic [31:0] cfgBase,
  input  logic [15:0] cfgLimit,
  input  logic        ldValid,
  input  logic [2:0]  ldSeg,
  input  logic [15:0] ldSelector,
  input  logic [1:0]  ldCpl,
  output logic        busy,
  output logic        ldDone,
  output logic        ldFault,
  output logic [2:0]  ldCode,
  output logic        memRdValid,
  output logic [31:0] memRdAddr,
  input  logic        memRdReady,
  input  logic [31:0] memRdData,
  input  logic        xlValid,
  input  logic [2:0]  xlSeg,
  input  logic [31:0] xlOffset,
  input  logic [1:0]  xlAccess,
  output logic        xlDone,
  output logic        xlFault,
  output logic [2:0]  xlCode,
  output logic [31:0] xlLinear
);
  ctrlStrobes_t strobes;
  logic         tblOk;

  seg_xlate_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .tblOk(tblOk),
    .memRdReady(memRdReady), .strobes(strobes),
    .memRdValid(memRdValid), .busy(busy)
  );

  seg_xlate_dp #(.NUM_SEGS(NUM_SEGS)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cfgWe(cfgWe), .cfgLocal(cfgLocal), .cfgBase(cfgBase), .cfgLimit(cfgLimit),
    .ldSeg(ldSeg), .ldSelector(ldSelector), .ldCpl(ldCpl),
    .tblOk(tblOk), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .ldDone(ldDone), .ldFault(ldFault), .ldCode(ldCode),
    .xlValid(xlValid), .xlSeg(xlSeg), .xlOffset(xlOffset), .xlAccess(xlAccess),
    .xlDone(xlDone), .xlFault(xlFault), .xlCode(xlCode), .xlLinear(xlLinear)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        ldDone,
  input logic        memRdValid,
  input logic        memRdReady,
  input logic [31:0] memRdAddr,
  input logic        xlValid,
  input logic        xlDone,
  input logic        xlFault,
  input logic [31:0] xlLinear
);
  assert_read_only_when_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> busy);

  assert_done_leaves_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    ldDone |-> !busy);

  assert_read_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && !memRdReady) |=> (memRdValid && $stable(memRdAddr)));

  assert_result_follows_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    xlValid |=> xlDone);

  assert_no_unrequested_result_R3: assert property (@(posedge clk) disable iff (!rstN)
    xlDone |-> $past(xlValid));

  assert_fault_no_address_R4: assert property (@(posedge clk) disable iff (!rstN)
    xlFault |-> (xlLinear == 32'd0));
endmodule

bind seg_xlate_unit seg_xlate_chk i_chk (.*);

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        cfgWe = 0, cfgLocal = 0;
  logic [31:0] cfgBase = 0;
  logic [15:0] cfgLimit = 0;
  logic        ldValid = 0;
  logic [2:0]  ldSeg = 0;
  logic [15:0] ldSelector = 0;
  logic [1:0]  ldCpl = 0;
  logic        busy, ldDone, ldFault;
  logic [2:0]  ldCode;
  logic        memRdValid;
  logic [31:0] memRdAddr;
  logic        memRdReady = 0;
  logic [31:0] memRdData = 0;
  logic        xlValid = 0;
  logic [2:0]  xlSeg = 0;
  logic [31:0] xlOffset = 0;
  logic [1:0]  xlAccess = 0;
  logic        xlDone, xlFault;
  logic [2:0]  xlCode;
  logic [31:0] xlLinear;

  seg_xlate_unit i_seg_xlate_unit (.*);

  int nChecks = 0, nFails = 0;
  logic [31:0] memArr [int unsigned];
  logic [31:0] addrQ[$];
  logic [34:0] xlQ[$];      // {code, linear}
  string       xlTagQ[$];
  logic [2:0]  ldQ[$];
  string       ldTagQ[$];

  localparam logic [31:0] GDT = 32'h0000_1000;
  localparam logic [31:0] LDT = 32'h0000_8000;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdMem(input logic [31:0] a);
    return memArr.exists(a) ? memArr[a] : 32'd0;
  endfunction

  task automatic setDesc(input logic [31:0] tbl, input int idx, input logic [31:0] base,
                         input logic [19:0] lim, input logic [1:0] dpl, input bit pres,
                         input bit code, input bit rw);
    memArr[tbl + idx*8]     = base;
    memArr[tbl + idx*8 + 4] = {7'd0, code, rw, pres, dpl, lim};
  endtask

  // memory responder: accepts a read every other cycle, checks addresses
  always @(negedge clk) begin
    if (memRdValid && !memRdReady) begin
      if (addrQ.size() == 0) check(0, "R6 unexpected read", memRdAddr, 0);
      else begin
        logic [31:0] e;
        e = addrQ.pop_front();
        check(memRdAddr == e, "R2 read address", memRdAddr, e);
      end
      memRdData  <= rdMem(memRdAddr);
      memRdReady <= 1'b1;
    end else memRdReady <= 1'b0;
  end

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rstN && xlDone) begin
      if (xlQ.size() == 0) check(0, "R3 unexpected result", xlLinear, 0);
      else begin
        logic [34:0] e;
        string t;
        e = xlQ.pop_front(); t = xlTagQ.pop_front();
        check({xlCode, xlLinear} == e && xlFault == (e[34:32] != 0), t,
              {xlCode, xlLinear}, e);
      end
    end
    if (rstN && ldDone) begin
      if (ldQ.size() == 0) check(0, "R10 unexpected done", ldCode, 0);
      else begin
        logic [2:0] e;
        string t;
        e = ldQ.pop_front(); t = ldTagQ.pop_front();
        check(ldCode == e && ldFault == (e != 0), t, ldCode, e);
      end
    end
  end

  task automatic cfgTable(input bit loc, input logic [31:0] b, input logic [15:0] l);
    @(negedge clk); cfgWe = 1; cfgLocal = loc; cfgBase = b; cfgLimit = l;
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic loadSeg(input int seg, input logic [15:0] sel, input logic [1:0] cpl,
                         input logic [2:0] expCode, input bit reads, input string tag,
                         input bit intrude);
    if (reads) begin
      logic [31:0] a;
      a = (sel[2] ? LDT : GDT) + {16'd0, sel[15:3], 3'd0};
      addrQ.push_back(a); addrQ.push_back(a + 4);
    end
    ldQ.push_back(expCode); ldTagQ.push_back(tag);
    @(negedge clk); ldValid = 1; ldSeg = 3'(seg); ldSelector = sel; ldCpl = cpl;
    @(negedge clk); ldValid = 0;
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
    if (intrude) begin
      ldValid = 1; ldSeg = 3'd5; ldSelector = 16'h00FB; ldCpl = 2'd3;
      @(negedge clk); ldValid = 0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    check(addrQ.size() == 0, "R2 two reads per load", addrQ.size(), 0);
  endtask

  task automatic xl(input int seg, input logic [31:0] off, input logic [1:0] acc,
                    input logic [31:0] expLin, input logic [2:0] expCode, input string tag);
    xlQ.push_back({expCode, expLin}); xlTagQ.push_back(tag);
    @(negedge clk); xlValid = 1; xlSeg = 3'(seg); xlOffset = off; xlAccess = acc;
    @(negedge clk); xlValid = 0;
  endtask

  task automatic runTests();
    repeat (3) @(negedge clk);
    check(busy == 0 && ldDone == 0 && xlDone == 0, "R1 reset outputs", {busy, ldDone, xlDone}, 0);
    rstN = 1;
    xl(0, 32'h10, 0, 0, 3, "R1 unloaded CS");
    xl(2, 32'h0,  1, 0, 3, "R1 unloaded DS");

    setDesc(GDT, 1, 32'h0040_0000, 20'h01FFF, 0, 1, 1, 1);
    setDesc(GDT, 2, 32'h0070_0000, 20'hFFFFF, 3, 1, 0, 1);
    setDesc(GDT, 3, 32'hFFFF_F000, 20'h02000, 3, 1, 0, 0);
    setDesc(GDT, 4, 32'h0600_0000, 20'h00FFF, 3, 0, 0, 1);
    setDesc(GDT, 5, 32'h0020_0000, 20'h000FF, 1, 1, 0, 1);
    setDesc(GDT, 6, 32'h0030_0000, 20'h000FF, 3, 1, 0, 1);
    memArr[GDT + 6*8 + 4] = memArr[GDT + 6*8 + 4] | 32'h8000_0000;
    setDesc(GDT, 31, 32'h0000_0500, 20'h00010, 3, 1, 0, 1);
    setDesc(LDT, 2, 32'h1234_0000, 20'h000FF, 3, 1, 0, 1);
    cfgTable(0, GDT, 16'h00FF);
    cfgTable(1, LDT, 16'h003F);

    loadSeg(0, 16'h0008, 0, 0, 1, "R10 load CS ok", 0);
    loadSeg(1, 16'h0013, 3, 0, 1, "R10 load SS ok", 0);
    loadSeg(2, 16'h0013, 3, 0, 1, "R10 load DS ok", 1);
    xl(5, 32'h0, 0, 0, 3, "R10 intruding load ignored");
    loadSeg(3, 16'h001B, 3, 0, 1, "R10 load ES ok", 0);
    loadSeg(4, 16'h0017, 3, 0, 1, "R2 load FS from local", 0);

    xl(0, 32'h10,   0, 32'h0040_0010, 0, "R3 CS read");
    xl(0, 32'h1FFF, 2, 32'h0040_1FFF, 0, "R4 CS exec at limit");
    xl(0, 32'h2000, 2, 0, 1, "R4 CS exec past limit");
    xl(0, 32'h10,   1, 0, 2, "R5 CS write");
    xl(0, 32'h2000, 1, 0, 1, "R5 limit before type");
    xl(2, 32'hABCD, 1, 32'h0070_ABCD, 0, "R3 DS write");
    xl(3, 32'h1800, 0, 32'h0000_0800, 0, "R3 ES wrap");
    xl(3, 32'h10,   1, 0, 2, "R5 ES write readonly");
    xl(3, 32'h10,   2, 0, 2, "R5 ES exec data");
    xl(4, 32'hFF,   0, 32'h1234_00FF, 0, "R2 FS local base");
    xl(4, 32'h100,  0, 0, 1, "R4 FS past limit");

    loadSeg(5, 16'h0143, 3, 4, 0, "R6 index past table", 0);
    xl(5, 32'h0, 0, 0, 3, "R6 GS unchanged");
    loadSeg(4, 16'h0044, 3, 4, 0, "R6 local index past table", 0);
    xl(4, 32'h20, 0, 32'h1234_0020, 0, "R6 FS unchanged");
    loadSeg(5, 16'h00FB, 3, 0, 1, "R6 last entry ok", 0);
    xl(5, 32'h10, 1, 32'h0000_0510, 0, "R6 GS last entry");

    loadSeg(2, 16'h0023, 3, 5, 1, "R7 not present", 0);
    loadSeg(2, 16'h0033, 3, 5, 1, "R7 reserved bit", 0);
    xl(2, 32'hABCD, 0, 32'h0070_ABCD, 0, "R7 DS unchanged");
    loadSeg(2, 16'h002A, 0, 6, 1, "R8 rpl too weak", 0);
    loadSeg(2, 16'h0028, 2, 6, 1, "R8 cpl too weak", 0);
    xl(2, 32'h10, 0, 32'h0070_0010, 0, "R8 DS unchanged");
    loadSeg(2, 16'h0029, 1, 0, 1, "R8 equal level ok", 0);
    xl(2, 32'h10, 0, 32'h0020_0010, 0, "R8 DS new base");
    xl(1, 32'h10, 0, 32'h0070_0010, 0, "R11 SS kept");

    memArr[GDT + 2*8] = 32'h0900_0000;
    xl(1, 32'h44, 1, 32'h0070_0044, 0, "R9 stale cache");
    loadSeg(1, 16'h0013, 3, 0, 1, "R9 reload SS", 0);
    xl(1, 32'h44, 1, 32'h0900_0044, 0, "R9 refreshed");
    xl(0, 32'h10, 0, 32'h0040_0010, 0, "R11 CS kept");

    repeat (3) @(negedge clk);
    check(xlQ.size() == 0 && ldQ.size() == 0, "R3 all results seen", xlQ.size() + ldQ.size(), 0);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule